// File: doc/BRIEF.md
# Pipelined Read Output Stage with Selectable Deselect Timing

This block is the read-side back end of a pipelined synchronous memory. It takes commands that the input register has already captured (no-op, read, write, deselect), registers the array's read word into an output stage, and decides cycle by cycle whether the data bus is driven. A read held in the input register in cycle c delivers its word on the bus from cycle c+1. Reads issued back to back therefore give one word per clock after the first.

A mode input selects how quickly a deselect shuts the bus off. In single-cycle mode the drive falls during the very cycle in which the deselect sits in the input register. In dual-cycle mode the bus keeps driving through that cycle and falls after the next rising edge, which is the same stage at which read data appears.

An active-low output enable and an active-high sleep input gate the drive without waiting for a clock. While sleep is high, every command is ignored and the held output word is kept.

Top module: `psr_read_out_top`

## Requirements
- R1: While rst_ni is low, whether asserted mid-cycle or held from power-up, dq_oe_o is low and dq_o is all zeros.
- R2: Command code 2'b01 (read) in cycle c, with sleep low, captures rdata_i from cycle c; dq_o shows that word from cycle c+1, and dq_oe_o is high then if oe_ni is low.
- R3: Consecutive reads produce a new word on dq_o every cycle, in issue order.
- R4: Command code 2'b00 (no-op) keeps the held word on dq_o and leaves the drive state unchanged.
- R5: With scd_i low (dual-cycle), deselect code 2'b11 in cycle c leaves the bus driven in cycle c and turns it off from cycle c+1 onward.
- R6: With scd_i high (single-cycle), deselect code 2'b11 turns the bus off in cycle c itself, and it stays off until the next read delivers data.
- R7: oe_ni high turns dq_oe_o off immediately without a clock edge and leaves dq_o unchanged; returning it low restores the drive.
- R8: sleep_i high turns dq_oe_o off immediately. Commands given during sleep have no effect, and after wake-up the word held before sleep is driven again.
- R9: Write code 2'b10 in cycle c forces dq_oe_o low in cycle c, and the bus stays off afterwards until a read delivers new data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scd_i | input | 1 | Deselect timing: 1 = single-cycle, 0 = dual-cycle |
| cmd_i | input | 2 | Registered command: 00 no-op, 01 read, 10 write, 11 deselect |
| rdata_i | input | DATA_W | Array read word for the read held in cmd_i |
| oe_ni | input | 1 | Output enable, active low, asynchronous |
| sleep_i | input | 1 | Sleep, active high, asynchronous |
| dq_o | output | DATA_W | Output-stage data word |
| dq_oe_o | output | 1 | Drive enable for the data bus |

## Verification
The hardest case to reach is a deselect arriving in the cycle right after a read. Here the two modes differ in whether the freshly loaded word ever reaches the bus. A second hard case is a sleep window that covers a pending valid word while read and deselect commands keep arriving. The vector table places these commands back to back in both modes and brings sleep up over a live result. Directed steps then toggle oe_ni, sleep_i and rst_ni in the middle of a cycle to expose the paths that do not go through a clock.

// File: rtl/psr_pkg.sv
package psr_pkg;
  typedef enum logic [1:0] {
    CMD_NOP   = 2'b00,
    CMD_READ  = 2'b01,
    CMD_WRITE = 2'b10,
    CMD_DESEL = 2'b11
  } cmd_e;
endpackage

// File: rtl/psr_cmd_decode.sv
module psr_cmd_decode
  import psr_pkg::*;
(
  input  logic [1:0] cmd_i,
  input  logic       sleep_i,
  output logic       rd_take_o,
  output logic       wr_now_o,
  output logic       dsl_now_o
);
  cmd_e cmd;

  always_comb begin
    cmd       = cmd_e'(cmd_i);
    // sleep swallows every command
    rd_take_o = !sleep_i && (cmd == CMD_READ);
    wr_now_o  = !sleep_i && (cmd == CMD_WRITE);
    dsl_now_o = !sleep_i && (cmd == CMD_DESEL);
  end
endmodule

// File: rtl/psr_out_stage.sv
module psr_out_stage #(
  parameter int DATA_W = 36
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              clear_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [DATA_W-1:0] q_o,
  output logic              vld_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_o   <= '0;
      vld_o <= 1'b0;
    end else if (load_i) begin
      q_o   <= rdata_i;
      vld_o <= 1'b1;
    end else if (clear_i) begin
      vld_o <= 1'b0;
    end
  end

  assert_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (vld_o && q_o == $past(rdata_i)));

  assert_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clear_i && !load_i) |=> !vld_o);

  assert_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !clear_i) |=> ($stable(q_o) && $stable(vld_o)));
endmodule

// File: rtl/psr_drive_ctrl.sv
module psr_drive_ctrl (
  input  logic vld_i,
  input  logic wr_now_i,
  input  logic dsl_now_i,
  input  logic scd_i,
  input  logic oe_ni,
  input  logic sleep_i,
  output logic oe_o
);
  logic scd_cut;

  always_comb begin
    // single-cycle mode kills drive while the deselect is in the input register
    scd_cut = scd_i && dsl_now_i;
    oe_o    = vld_i && !oe_ni && !sleep_i && !wr_now_i && !scd_cut;
  end
endmodule

// File: rtl/psr_read_out_top.sv
module psr_read_out_top #(
  parameter int DATA_W = 36
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scd_i,
  input  logic [1:0]        cmd_i,
  input  logic [DATA_W-1:0] rdata_i,
  input  logic              oe_ni,
  input  logic              sleep_i,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe_o
);
  logic rd_take, wr_now, dsl_now, vld;

  psr_cmd_decode i_dec (
    .cmd_i     (cmd_i),
    .sleep_i   (sleep_i),
    .rd_take_o (rd_take),
    .wr_now_o  (wr_now),
    .dsl_now_o (dsl_now)
  );

  psr_out_stage #(.DATA_W(DATA_W)) i_stage (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (rd_take),
    .clear_i (wr_now | dsl_now),
    .rdata_i (rdata_i),
    .q_o     (dq_o),
    .vld_o   (vld)
  );

  psr_drive_ctrl i_drv (
    .vld_i     (vld),
    .wr_now_i  (wr_now),
    .dsl_now_i (dsl_now),
    .scd_i     (scd_i),
    .oe_ni     (oe_ni),
    .sleep_i   (sleep_i),
    .oe_o      (dq_oe_o)
  );

  assert_sleep_off_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_i |-> !dq_oe_o);

  assert_scd_cut_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scd_i && !sleep_i && cmd_i == 2'b11) |-> !dq_oe_o);

  assert_write_off_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sleep_i && cmd_i == 2'b10) |-> !dq_oe_o);

  assert_oe_off_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_ni |-> !dq_oe_o);

  assert_sleep_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_i |=> $stable(dq_o));
endmodule

// File: tb/test_psr_read_out_top.sv
module test_psr_read_out_top;
  localparam int DW = 36;

  typedef struct packed {
    logic [1:0]    cmd;
    logic          scd;
    logic          oe_n;
    logic          sleep;
    logic [DW-1:0] rdata;
    logic          exp_oe;
    logic [DW-1:0] exp_dq;
    logic [3:0]    req;
  } vec_t;

  localparam logic [DW-1:0] W_A1 = 36'h1_1111_1111;
  localparam logic [DW-1:0] W_A2 = 36'h2_2222_2222;
  localparam logic [DW-1:0] W_A3 = 36'h3_3333_3333;
  localparam logic [DW-1:0] W_B1 = 36'h4_4444_4444;
  localparam logic [DW-1:0] W_C1 = 36'h5_5555_5555;
  localparam logic [DW-1:0] W_D1 = 36'h6_6666_6666;
  localparam logic [DW-1:0] W_E1 = 36'h7_7777_7777;
  localparam logic [DW-1:0] W_F1 = 36'h8_8888_8888;
  localparam logic [DW-1:0] W_G1 = 36'h9_ABCD_EF01;
  localparam logic [DW-1:0] Z    = '0;

  localparam int NV = 24;
  // cmd, scd, oe_n, sleep, rdata, exp_oe, exp_dq, requirement
  localparam vec_t VECS [NV] = '{
    '{2'b00, 1'b1, 1'b0, 1'b0, Z,    1'b0, Z,    4'd1},  // R1 idle after reset
    '{2'b01, 1'b1, 1'b0, 1'b0, W_A1, 1'b0, Z,    4'd2},  // R2 read issued
    '{2'b01, 1'b1, 1'b0, 1'b0, W_A2, 1'b1, W_A1, 4'd2},  // R2 first word
    '{2'b01, 1'b1, 1'b0, 1'b0, W_A3, 1'b1, W_A2, 4'd3},  // R3 burst
    '{2'b00, 1'b1, 1'b0, 1'b0, Z,    1'b1, W_A3, 4'd3},  // R3 burst
    '{2'b00, 1'b1, 1'b0, 1'b0, Z,    1'b1, W_A3, 4'd4},  // R4 hold
    '{2'b00, 1'b1, 1'b1, 1'b0, Z,    1'b0, W_A3, 4'd7},  // R7 oe high
    '{2'b00, 1'b1, 1'b0, 1'b0, Z,    1'b1, W_A3, 4'd7},  // R7 oe back
    '{2'b11, 1'b1, 1'b0, 1'b0, Z,    1'b0, W_A3, 4'd6},  // R6 cut now
    '{2'b00, 1'b1, 1'b0, 1'b0, Z,    1'b0, W_A3, 4'd6},  // R6 stays off
    '{2'b01, 1'b0, 1'b0, 1'b0, W_B1, 1'b0, W_A3, 4'd2},
    '{2'b11, 1'b0, 1'b0, 1'b0, Z,    1'b1, W_B1, 4'd5},  // R5 still driven
    '{2'b00, 1'b0, 1'b0, 1'b0, Z,    1'b0, W_B1, 4'd5},  // R5 off next
    '{2'b01, 1'b0, 1'b0, 1'b0, W_C1, 1'b0, W_B1, 4'd2},
    '{2'b10, 1'b0, 1'b0, 1'b0, Z,    1'b0, W_C1, 4'd9},  // R9 write cycle
    '{2'b00, 1'b0, 1'b0, 1'b0, Z,    1'b0, W_C1, 4'd9},  // R9 stays off
    '{2'b01, 1'b0, 1'b0, 1'b0, W_D1, 1'b0, W_C1, 4'd2},
    '{2'b00, 1'b0, 1'b0, 1'b1, Z,    1'b0, W_D1, 4'd8},  // R8 sleep off
    '{2'b01, 1'b0, 1'b0, 1'b1, W_E1, 1'b0, W_D1, 4'd8},  // R8 read ignored
    '{2'b11, 1'b0, 1'b0, 1'b1, Z,    1'b0, W_D1, 4'd8},  // R8 deselect ignored
    '{2'b00, 1'b0, 1'b0, 1'b0, Z,    1'b1, W_D1, 4'd8},  // R8 wake, held word
    '{2'b01, 1'b1, 1'b0, 1'b0, W_F1, 1'b1, W_D1, 4'd4},
    '{2'b11, 1'b1, 1'b0, 1'b0, Z,    1'b0, W_F1, 4'd6},  // R6 read then cut
    '{2'b00, 1'b1, 1'b0, 1'b0, Z,    1'b0, W_F1, 4'd6}
  };

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          scd_i = 1'b1;
  logic [1:0]    cmd_i = 2'b00;
  logic [DW-1:0] rdata_i = '0;
  logic          oe_ni = 1'b0;
  logic          sleep_i = 1'b0;
  logic [DW-1:0] dq_o;
  logic          dq_oe_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  psr_read_out_top #(.DATA_W(DW)) i_psr_read_out_top (
    .clk_i   (clk),
    .rst_ni  (rst_ni),
    .scd_i   (scd_i),
    .cmd_i   (cmd_i),
    .rdata_i (rdata_i),
    .oe_ni   (oe_ni),
    .sleep_i (sleep_i),
    .dq_o    (dq_o),
    .dq_oe_o (dq_oe_o)
  );

  task automatic chk(input string tag, input logic e_oe, input logic [DW-1:0] e_dq);
    checks++;
    if (dq_oe_o !== e_oe || dq_o !== e_dq) begin
      failures++;
      $display("FAIL %s: act oe=%0b dq=%h exp oe=%0b dq=%h", tag, dq_oe_o, dq_o, e_oe, e_dq);
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog: act running exp finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    #1 chk("R1 in reset", 1'b0, Z);
    cmd_i = 2'b01; rdata_i = W_G1;
    repeat (2) @(negedge clk);
    #1 chk("R1 read ignored in reset", 1'b0, Z);
    cmd_i = 2'b00;
    rst_ni = 1'b1;

    for (int k = 0; k < NV; k++) begin
      cmd_i   = VECS[k].cmd;
      scd_i   = VECS[k].scd;
      oe_ni   = VECS[k].oe_n;
      sleep_i = VECS[k].sleep;
      rdata_i = VECS[k].rdata;
      #2 chk($sformatf("R%0d vec %0d", VECS[k].req, k), VECS[k].exp_oe, VECS[k].exp_dq);
      @(negedge clk);
    end

    // directed: asynchronous paths mid-cycle
    cmd_i = 2'b01; rdata_i = W_G1; scd_i = 1'b0; oe_ni = 1'b0; sleep_i = 1'b0;
    @(negedge clk);
    cmd_i = 2'b00; rdata_i = Z;
    #1 chk("R2 directed read", 1'b1, W_G1);
    oe_ni = 1'b1;
    #1 chk("R7 async oe off", 1'b0, W_G1);
    oe_ni = 1'b0;
    #1 chk("R7 async oe on", 1'b1, W_G1);
    sleep_i = 1'b1;
    #1 chk("R8 async sleep off", 1'b0, W_G1);
    sleep_i = 1'b0;
    #1 chk("R8 async wake", 1'b1, W_G1);
    @(negedge clk);
    #1 rst_ni = 1'b0;
    #1 chk("R1 async reset mid-cycle", 1'b0, Z);
    @(negedge clk);
    rst_ni = 1'b1;
    #2 chk("R1 after reset release", 1'b0, Z);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule